// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Capture Sequencer

This block runs a four-channel, parallel-output converter whose channels are all sampled at the same instant, and it collects the results so a host can fetch them in bursts. An internal timebase, whose period in clocks is set on an input, fires a one-cycle conversion-start pulse. The sequencer then waits for end-of-conversion. It pulses an active-low read strobe four times and latches the 12-bit data bus as each strobe releases. The converter presents its channels in a fixed rotation, so the four words come back as channels 0, 1, 2 and 3.

Each word is tagged with its channel and pushed into a 64-entry first-word-fall-through sample queue. An interrupt line rises once 32 samples are waiting, which gives a DMA engine one 32-sample burst. A free-running microsecond counter is captured once per 32-sample buffer, at the write of that buffer's first sample. The captured value is shown on a timestamp output for as long as that buffer is at the head of the queue. The time of any other sample follows from the fixed sample period. If the queue cannot take a whole group of four, the group is discarded. A missing end-of-conversion ends the sequence after a timeout. Both events set sticky error flags that only reset clears.

Top module: `adc_capture_seq`

## Requirements
- R1: While `enable_i` is high, `adc_convst_o` gives a pulse exactly one clock wide, and consecutive pulses are `period_i` clocks apart. A pulse is issued only when no sequence is in progress.
- R2: After `adc_eoc_i` is seen high, `adc_rd_n_o` goes low four times, each time for exactly RD_LOW_CYC clocks, with at least one high clock between strobes. It never goes low while a conversion start is being issued.
- R3: Each stored sample is 14 bits: bits [13:12] hold the channel number and bits [11:0] hold the data bus value present while the strobe was low. Channels are written in the order 0, 1, 2, 3.
- R4: The sample queue holds 64 entries and is first-word-fall-through: `host_data_o` shows the oldest sample, and `host_rd_i` removes it. A read while the queue is empty changes nothing.
- R5: `irq_o` is high exactly when `host_level_o` is 32 or more.
- R6: A timestamp counter advances by one every TS_DIV clocks. `host_ts_o` gives its value at the write of the first sample of the 32-sample buffer now at the head of the queue. It moves to the next buffer's value after that buffer's 32nd sample is read.
- R7: If fewer than four entries are free when end-of-conversion arrives, all four samples of that group are discarded and `err_ovf_o` becomes 1 and stays 1 until reset.
- R8: If end-of-conversion has not arrived EOC_TIMEOUT clocks after a start, the sequence ends with no read strobe, and `err_tmo_o` becomes 1 and stays 1 until reset. The next period starts a normal sequence.
- R9: During and right after reset: no start pulse, read strobe high, queue empty with level 0, interrupt low, both error flags low.
- R10: A new value on `period_i` sets the spacing of later start pulses without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Allows periodic conversion starts |
| period_i | input | PER_W | Clocks between conversion starts |
| adc_eoc_i | input | 1 | End-of-conversion from the converter, active high |
| adc_data_i | input | 12 | Converter parallel data bus |
| adc_convst_o | output | 1 | Conversion-start pulse, one clock wide |
| adc_rd_n_o | output | 1 | Active-low read strobe |
| host_rd_i | input | 1 | Removes the head sample |
| host_data_o | output | 14 | Head sample {channel, data} |
| host_empty_o | output | 1 | Queue empty |
| host_level_o | output | 7 | Number of stored samples |
| host_ts_o | output | TS_W | Timestamp of the head buffer |
| irq_o | output | 1 | Half-full interrupt |
| err_ovf_o | output | 1 | Sticky group-dropped flag |
| err_tmo_o | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
The hardest state to reach from the ports is a full queue at the moment a new end-of-conversion arrives. The drop has to discard all four samples and leave the stored data and the buffer timestamps intact. The stimulus gets there by letting the timebase run for eighteen periods with no host reads. Every stored word carries its conversion index, so draining all 64 entries shows that exactly the first sixteen groups were kept, in order. The same drain compares the timestamps of the two buffers against their known spacing of eight sample periods.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_NUM = 4;
    localparam int CH_W   = 2;
    localparam int SMP_W  = 12;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [SMP_W-1:0] data;
    } sample_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_WAIT,
        SQ_STROBE,
        SQ_GAP
    } seq_state_e;

    function automatic logic is_last_ch(input logic [CH_W-1:0] c);
        return c == CH_W'(CH_NUM - 1);
    endfunction

endpackage

// File: rtl/adc_timebase.sv
module adc_timebase #(
    parameter int PER_W  = 16,
    parameter int TS_DIV = 100,
    parameter int TS_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             tick,
    output logic [TS_W-1:0]  ts_now
);
    localparam int DIV_W = $clog2(TS_DIV + 1);

    logic [PER_W-1:0] per_cnt;
    logic [DIV_W-1:0] div_cnt;

    assign tick = en && (per_cnt >= period - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            per_cnt <= '0;
        end else begin
            per_cnt <= per_cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            ts_now  <= '0;
        end else if (div_cnt == DIV_W'(TS_DIV - 1)) begin
            div_cnt <= '0;
            ts_now  <= ts_now + TS_W'(1);
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_seq_pkg::*;
#(
    parameter int RD_LOW_CYC  = 4,
    parameter int EOC_TIMEOUT = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             eoc,
    input  logic [SMP_W-1:0] adc_data,
    input  logic             room,
    output logic             conv_start,
    output logic             rd_n,
    output logic             wr_en,
    output sample_t          wr_sample,
    output logic             err_ovf,
    output logic             err_tmo
);
    localparam int CNT_MAX = (RD_LOW_CYC > EOC_TIMEOUT) ? RD_LOW_CYC : EOC_TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  ch;
    logic             drop;

    assign conv_start = (state == SQ_START);
    assign rd_n       = (state != SQ_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            ch        <= '0;
            drop      <= 1'b0;
            wr_en     <= 1'b0;
            wr_sample <= '0;
            err_ovf   <= 1'b0;
            err_tmo   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (tick) state <= SQ_START;
                end
                SQ_START: begin
                    state <= SQ_WAIT;
                    cnt   <= '0;
                end
                SQ_WAIT: begin
                    if (eoc) begin
                        state <= SQ_STROBE;
                        cnt   <= '0;
                        ch    <= '0;
                        drop  <= !room;
                        if (!room) err_ovf <= 1'b1;
                    end else if (cnt == CNT_W'(EOC_TIMEOUT - 1)) begin
                        state   <= SQ_IDLE;
                        err_tmo <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_STROBE: begin
                    if (cnt == CNT_W'(RD_LOW_CYC - 1)) begin
                        state     <= SQ_GAP;
                        wr_en     <= !drop;
                        wr_sample <= '{ch: ch, data: adc_data};
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_GAP: begin
                    if (is_last_ch(ch)) begin
                        state <= SQ_IDLE;
                    end else begin
                        ch    <= ch + CH_W'(1);
                        cnt   <= '0;
                        state <= SQ_STROBE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
    import adc_seq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int BUF_LEN = 32,
    parameter int TS_W    = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  sample_t                  wr_data,
    input  logic [TS_W-1:0]          ts_now,
    input  logic                     rd_en,
    output sample_t                  rd_data,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level,
    output logic [TS_W-1:0]          ts_head
);
    localparam int AW    = $clog2(DEPTH);
    localparam int BW    = $clog2(BUF_LEN);
    localparam int TQ_AW = $clog2(DEPTH / BUF_LEN + 1);
    localparam int TQ_D  = 1 << TQ_AW;

    sample_t           mem [DEPTH];
    logic [TS_W-1:0]   tq  [TQ_D];
    logic [AW:0]       wp, rp;
    logic [TQ_AW-1:0]  tq_wp, tq_rp;
    logic              full, do_wr, do_rd, push_ts, pop_ts;

    assign level   = wp - rp;
    assign empty   = (wp == rp);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign push_ts = do_wr && (wp[BW-1:0] == '0);
    assign pop_ts  = do_rd && (rp[BW-1:0] == BW'(BUF_LEN - 1));
    assign rd_data = mem[rp[AW-1:0]];
    assign ts_head = tq[tq_rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp[AW-1:0]] <= wr_data;
        if (push_ts) tq[tq_wp] <= ts_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            tq_wp <= '0;
            tq_rp <= '0;
        end else begin
            if (do_wr)   wp    <= wp + (AW+1)'(1);
            if (do_rd)   rp    <= rp + (AW+1)'(1);
            if (push_ts) tq_wp <= tq_wp + TQ_AW'(1);
            if (pop_ts)  tq_rp <= tq_rp + TQ_AW'(1);
        end
    end

endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
    import adc_seq_pkg::*;
#(
    parameter int PER_W       = 16,
    parameter int TS_DIV      = 100,
    parameter int TS_W        = 32,
    parameter int FIFO_DEPTH  = 64,
    parameter int RD_LOW_CYC  = 4,
    parameter int EOC_TIMEOUT = 400
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         enable_i,
    input  logic [PER_W-1:0]             period_i,
    input  logic                         adc_eoc_i,
    input  logic [SMP_W-1:0]             adc_data_i,
    output logic                         adc_convst_o,
    output logic                         adc_rd_n_o,
    input  logic                         host_rd_i,
    output logic [CH_W+SMP_W-1:0]        host_data_o,
    output logic                         host_empty_o,
    output logic [$clog2(FIFO_DEPTH):0]  host_level_o,
    output logic [TS_W-1:0]              host_ts_o,
    output logic                         irq_o,
    output logic                         err_ovf_o,
    output logic                         err_tmo_o
);
    localparam int LW      = $clog2(FIFO_DEPTH) + 1;
    localparam int BUF_LEN = FIFO_DEPTH / 2;

    logic            tick;
    logic [TS_W-1:0] ts_now;
    logic            room;
    logic            wr_en;
    sample_t         wr_sample;
    sample_t         head;
    logic [LW-1:0]   level;

    assign room         = (level <= LW'(FIFO_DEPTH - CH_NUM));
    assign host_data_o  = head;
    assign host_level_o = level;
    assign irq_o        = (level >= LW'(BUF_LEN));

    adc_timebase #(
        .PER_W (PER_W),
        .TS_DIV(TS_DIV),
        .TS_W  (TS_W)
    ) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .en    (enable_i),
        .period(period_i),
        .tick  (tick),
        .ts_now(ts_now)
    );

    adc_rd_seq #(
        .RD_LOW_CYC (RD_LOW_CYC),
        .EOC_TIMEOUT(EOC_TIMEOUT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .eoc       (adc_eoc_i),
        .adc_data  (adc_data_i),
        .room      (room),
        .conv_start(adc_convst_o),
        .rd_n      (adc_rd_n_o),
        .wr_en     (wr_en),
        .wr_sample (wr_sample),
        .err_ovf   (err_ovf_o),
        .err_tmo   (err_tmo_o)
    );

    adc_sample_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .BUF_LEN(BUF_LEN),
        .TS_W   (TS_W)
    ) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_sample),
        .ts_now (ts_now),
        .rd_en  (host_rd_i),
        .rd_data(head),
        .empty  (host_empty_o),
        .level  (level),
        .ts_head(host_ts_o)
    );

endmodule

// File: rtl/adc_capture_seq_chk.sv
module adc_capture_seq_chk #(
    parameter int FIFO_DEPTH = 64,
    parameter int RD_LOW_CYC = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        conv_start,
    input logic                        rd_n,
    input logic [$clog2(FIFO_DEPTH):0] level,
    input logic                        irq,
    input logic                        err_ovf,
    input logic                        err_tmo,
    input logic                        host_rd
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;
    localparam int CW = $clog2(RD_LOW_CYC + 1) + 1;

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)        low_cnt <= '0;
        else if (!rd_n) low_cnt <= low_cnt + CW'(1);
        else            low_cnt <= '0;
    end

    // R1
    convst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> low_cnt == CW'(RD_LOW_CYC));

    // R2
    no_strobe_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> rd_n);

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(FIFO_DEPTH));

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> level == LW'(FIFO_DEPTH / 2));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_ovf |=> err_ovf);

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (level == LW'(FIFO_DEPTH) && !host_rd) |=> level == LW'(FIFO_DEPTH));

    // R8
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_tmo |=> err_tmo);

endmodule

bind adc_capture_seq adc_capture_seq_chk #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .RD_LOW_CYC(RD_LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_start(adc_convst_o),
    .rd_n      (adc_rd_n_o),
    .level     (host_level_o),
    .irq       (irq_o),
    .err_ovf   (err_ovf_o),
    .err_tmo   (err_tmo_o),
    .host_rd   (host_rd_i)
);

// File: tb/tb_adc_capture_seq.sv
module tb_adc_capture_seq;

    localparam int PER_W   = 16;
    localparam int TS_DIV  = 4;
    localparam int TS_W    = 32;
    localparam int DEPTH   = 64;
    localparam int RD_LOW  = 3;
    localparam int TMO     = 50;
    localparam int EOC_LAT = 4;
    localparam int PERIOD  = 200;
    localparam int NVEC    = 8;
    localparam logic [11:0] VEC [NVEC] = '{12'h000, 12'hFFF, 12'hA5A, 12'h5A5,
                                           12'h123, 12'h800, 12'h7FF, 12'h0F0};

    logic             clk = 1'b0;
    logic             rst;
    logic             enable_i;
    logic [PER_W-1:0] period_i;
    logic             adc_eoc_i;
    logic [11:0]      adc_data_i;
    logic             adc_convst_o;
    logic             adc_rd_n_o;
    logic             host_rd_i;
    logic [13:0]      host_data_o;
    logic             host_empty_o;
    logic [6:0]       host_level_o;
    logic [TS_W-1:0]  host_ts_o;
    logic             irq_o;
    logic             err_ovf_o;
    logic             err_tmo_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_capture_seq #(
        .PER_W(PER_W), .TS_DIV(TS_DIV), .TS_W(TS_W), .FIFO_DEPTH(DEPTH),
        .RD_LOW_CYC(RD_LOW), .EOC_TIMEOUT(TMO)
    ) dut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .period_i(period_i),
        .adc_eoc_i(adc_eoc_i), .adc_data_i(adc_data_i),
        .adc_convst_o(adc_convst_o), .adc_rd_n_o(adc_rd_n_o),
        .host_rd_i(host_rd_i), .host_data_o(host_data_o),
        .host_empty_o(host_empty_o), .host_level_o(host_level_o),
        .host_ts_o(host_ts_o), .irq_o(irq_o),
        .err_ovf_o(err_ovf_o), .err_tmo_o(err_tmo_o)
    );

    // converter model: ring of four channels, end-of-conversion after EOC_LAT
    bit          no_eoc   = 1'b0;
    bit          tbl_mode = 1'b1;
    logic [11:0] tbl_base = 12'h000;
    logic [1:0]  m_ptr    = '0;
    int          m_dly    = 0;
    int          m_seen   = 0;
    int          m_cur    = 0;
    logic        prev_rd_n = 1'b1;
    logic        prev_cs   = 1'b0;

    // monitor counters
    int cyc = 0, n_start = 0, st_last = 0, st_prev = 0;
    int n_strobe = 0, low_run = 0, last_low = 0, bad_pulse = 0;

    initial adc_eoc_i = 1'b0;

    always @(negedge clk) begin
        adc_eoc_i <= 1'b0;
        if (rst) begin
            m_ptr <= '0;
            m_dly <= 0;
            m_seen <= 0;
            m_cur <= 0;
            prev_rd_n <= 1'b1;
        end else begin
            prev_rd_n <= adc_rd_n_o;
            if (adc_convst_o) begin
                m_ptr <= '0;
                m_cur <= m_seen;
                m_seen <= m_seen + 1;
                m_dly <= no_eoc ? 0 : EOC_LAT;
            end else if (m_dly != 0) begin
                m_dly <= m_dly - 1;
                if (m_dly == 1) adc_eoc_i <= 1'b1;
            end
            if (adc_rd_n_o && !prev_rd_n) m_ptr <= m_ptr + 2'd1;
        end
    end

    assign adc_data_i = tbl_mode ? (tbl_base ^ ({10'd0, m_ptr} * 12'h0A5))
                                 : {m_cur[9:0], m_ptr};

    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_cs <= adc_convst_o;
        if (adc_convst_o) begin
            st_prev <= st_last;
            st_last <= cyc;
            n_start <= n_start + 1;
            if (prev_cs) bad_pulse <= bad_pulse + 1;
        end
        if (!adc_rd_n_o) begin
            low_run <= low_run + 1;
        end else if (low_run != 0) begin
            last_low <= low_run;
            n_strobe <= n_strobe + 1;
            low_run <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_level(input int n);
        for (int k = 0; k < 6000; k++) begin
            if (host_level_o == 7'(n)) return;
            @(negedge clk);
        end
        chk(1'b0, "wait_level", longint'(host_level_o), n);
    endtask

    task automatic wait_starts(input int n);
        int s0;
        s0 = n_start;
        for (int k = 0; k < 6000; k++) begin
            if (n_start >= s0 + n) return;
            @(negedge clk);
        end
        chk(1'b0, "wait_starts", n_start - s0, n);
    endtask

    task automatic pop_check(input logic [13:0] exp, input string req);
        chk(host_data_o == exp, req, longint'(host_data_o), longint'(exp));
        host_rd_i = 1'b1;
        @(negedge clk);
        host_rd_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enable_i = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int sb, ts0, ts1, strobes0;
        rst = 1'b1;
        enable_i = 1'b0;
        period_i = PER_W'(PERIOD);
        host_rd_i = 1'b0;
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(!adc_convst_o && adc_rd_n_o, "R9 strobes idle", {adc_convst_o, adc_rd_n_o}, 2'b01);
        chk(host_empty_o && host_level_o == 0, "R9 queue empty", host_level_o, 0);
        chk(!irq_o && !err_ovf_o && !err_tmo_o, "R9 flags low", {irq_o, err_ovf_o, err_tmo_o}, 0);
        rst = 1'b0;
        @(negedge clk);

        // vector table: one conversion per entry, drained after each (R3, R2)
        tbl_mode = 1'b1;
        tbl_base = VEC[0];
        strobes0 = n_strobe;
        enable_i = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            tbl_base = VEC[i];
            if (i == 3) begin
                // R4 read on empty queue has no effect
                host_rd_i = 1'b1;
                @(negedge clk);
                host_rd_i = 1'b0;
                @(negedge clk);
                chk(host_empty_o && host_level_o == 0, "R4 empty read", host_level_o, 0);
            end
            wait_level(4);
            for (int c = 0; c < 4; c++)
                pop_check({2'(c), VEC[i] ^ (12'(c) * 12'h0A5)}, "R3 sample word");
        end
        chk(n_strobe - strobes0 == 4 * NVEC, "R2 strobe count", n_strobe - strobes0, 4 * NVEC);
        chk(last_low == RD_LOW, "R2 strobe width", last_low, RD_LOW);
        chk(st_last - st_prev == PERIOD, "R1 start spacing", st_last - st_prev, PERIOD);
        chk(bad_pulse == 0, "R1 single-cycle start", bad_pulse, 0);

        // R10 period change on the fly
        period_i = PER_W'(120);
        wait_starts(3);
        chk(st_last - st_prev == 120, "R10 new spacing", st_last - st_prev, 120);

        // half-full, timestamps, overflow (R5, R6, R7)
        do_reset();
        tbl_mode = 1'b0;
        period_i = PER_W'(PERIOD);
        enable_i = 1'b1;
        wait_level(28);
        chk(!irq_o, "R5 irq below half", irq_o, 0);
        wait_level(32);
        chk(irq_o, "R5 irq at half", irq_o, 1);
        wait_level(64);
        for (int k = 0; k < 6000 && m_seen < 18; k++) @(negedge clk);
        repeat (60) @(negedge clk);
        enable_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(host_level_o == 64, "R7 level held at full", host_level_o, 64);
        chk(err_ovf_o, "R7 overflow flag", err_ovf_o, 1);
        ts0 = 0;
        for (int k = 0; k < 64; k++) begin
            if (k == 0) ts0 = int'(host_ts_o);
            if (k == 32) begin
                ts1 = int'(host_ts_o);
                chk(ts1 - ts0 == 8 * PERIOD / TS_DIV, "R6 buffer timestamp delta",
                    ts1 - ts0, 8 * PERIOD / TS_DIV);
            end
            pop_check({2'(k % 4), 10'(k / 4), 2'(k % 4)}, "R7 kept groups in order");
        end
        chk(host_empty_o, "R4 drained", host_level_o, 0);
        chk(err_ovf_o, "R7 flag sticky", err_ovf_o, 1);

        // timeout (R8)
        do_reset();
        tbl_mode = 1'b1;
        tbl_base = VEC[2];
        no_eoc = 1'b1;
        enable_i = 1'b1;
        wait_starts(1);
        sb = n_strobe;
        repeat (TMO - 5) @(negedge clk);
        chk(!err_tmo_o, "R8 no early timeout", err_tmo_o, 0);
        repeat (10) @(negedge clk);
        chk(err_tmo_o, "R8 timeout flag", err_tmo_o, 1);
        chk(n_strobe == sb && host_level_o == 0, "R8 no strobe on timeout", n_strobe - sb, 0);
        no_eoc = 1'b0;
        wait_level(4);
        pop_check({2'd0, VEC[2]}, "R8 resumes next period");
        chk(err_tmo_o, "R8 flag sticky", err_tmo_o, 1);

        // R9 reset clears sticky flags
        do_reset();
        chk(!err_tmo_o && !err_ovf_o && host_level_o == 0, "R9 reset clears",
            {err_ovf_o, err_tmo_o}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule